// File: doc/BRIEF.md
# Lithium Cell Charge Sequencer

This block sequences the charge cycle of a single lithium cell. Analog comparators and an external safety timer do the measuring. The block only decides which phase the charger is in. It takes digitized comparator flags and timer expiry strobes. Its outputs are:

- the precharge and fast-charge current enables,
- a small fault-probe current enable,
- run, clear and freeze controls for the timer,
- two status bits that drive open-drain indicators.

The four battery comparator flags pass through stable-count filters before the state machine sees them:

- cell below the low-voltage threshold,
- cell below the recharge threshold,
- taper current reached,
- temperature out of range.

A cycle moves from precharge to fast charge. It ends in a done state when taper current is seen, and starts again once the cell sags below the recharge threshold. A temperature excursion suspends charging and freezes the timers. A timer expiry is a fault, and the recovery path depends on where the cell sits relative to the recharge threshold. Removing the charge enable or the input source clears everything back to the sleep state.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: Each of the four comparator flags takes a new value only after its raw input has held that value on DG_TICKS consecutive clock edges. A shorter excursion has no effect on the outputs.
- R2: With charge enable and source both high, the block leaves sleep. It enters precharge (pre_en=1, tmr_pre_run=1) if the filtered low flag is set, and fast charge (fast_en=1, tmr_fast_run=1) otherwise. Either entry pulses tmr_rst for one cycle.
- R3: In precharge, clearing of the low flag moves the block to fast charge with a one-cycle tmr_rst pulse and tmr_fast_run=1.
- R4: A pre_tmo strobe in precharge, or a fast_tmo strobe in fast charge, drops both charge enables and enters a fault state.
- R5: In fast charge, the filtered taper flag moves the block to done (both charge enables off). The taper flag is ignored while therm_reg is high.
- R6: In done, the filtered recharge flag starts a new cycle as in R2.
- R7: Out-of-range temperature in precharge or fast charge drops the charge enables and raises tmr_hold. The phase's run bit stays set and tmr_rst stays low. Timeout strobes are ignored during the suspension. When the temperature flag clears, the same phase resumes without a tmr_rst pulse.
- R8: The status bits {stat1_on, stat2_on} read 11 in precharge, 10 in fast charge and 01 in done. They read 00 in sleep, suspension and fault, where 1 means the open-drain device conducts.
- R9: A fault entered with the recharge flag clear waits with no current enabled. Once the recharge flag sets, the fault is cleared and a new cycle starts as in R2.
- R10: A fault entered with the recharge flag set raises flt_cur_en. It stays high until the recharge flag clears, then drops and recovery continues as in R9.
- R11: Whenever charge enable or source is low, the block goes to sleep on the next edge with all outputs low. This clears any fault.
- R12: During and right after reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_en | input | 1 | Charge enable |
| src_ok | input | 1 | An input supply is present |
| bat_low_raw | input | 1 | Cell below low-voltage threshold (unfiltered) |
| bat_rch_raw | input | 1 | Cell below recharge threshold (unfiltered) |
| taper_raw | input | 1 | Charge current has tapered to the termination level (unfiltered) |
| temp_bad_raw | input | 1 | Cell temperature out of range (unfiltered) |
| therm_reg | input | 1 | Die thermal regulation is limiting current |
| pre_tmo | input | 1 | Precharge timer expiry strobe |
| fast_tmo | input | 1 | Fast-charge timer expiry strobe |
| pre_en | output | 1 | Precharge current enable |
| fast_en | output | 1 | Fast-charge current enable |
| flt_cur_en | output | 1 | Fault-probe current enable |
| tmr_rst | output | 1 | One-cycle clear of all timers |
| tmr_pre_run | output | 1 | Precharge timer selected to run |
| tmr_fast_run | output | 1 | Fast-charge timer selected to run |
| tmr_hold | output | 1 | Freeze timers at their current value |
| stat1_on | output | 1 | Status bit 1, open-drain device on |
| stat2_on | output | 1 | Status bit 2, open-drain device on |

## Verification
The bench builds the block with DG_TICKS=4. A filter window then spans only a few cycles, so both sides of the boundary are reachable: a temperature excursion of DG_TICKS-1 cycles that must be swallowed, and one that must suspend the charge. With the window that short, slowly toggling random flags and sparse timeout strobes visit every state, including both fault-recovery paths and suspension of either phase, within a few thousand cycles. A cycle-accurate reference built from the requirements is compared against every output on every cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP     = 3'd0,
    ST_PRE       = 3'd1,
    ST_FAST      = 3'd2,
    ST_DONE      = 3'd3,
    ST_SUSP_PRE  = 3'd4,
    ST_SUSP_FAST = 3'd5,
    ST_FLT_PROBE = 3'd6,
    ST_FLT_WAIT  = 3'd7
  } chg_state_e;

  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned FL_LOW    = 0;
  localparam int unsigned FL_RCH    = 1;
  localparam int unsigned FL_TAPER  = 2;
  localparam int unsigned FL_TEMP   = 3;

endpackage

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic flt
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LIM = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      flt <= 1'b0;
    end else if (raw == flt) begin
      cnt <= '0;
    end else if (cnt == LIM) begin
      flt <= raw;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // a filtered change always follows the level the raw input carried
  AST_DG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flt != $past(flt)) |-> ($past(raw) == flt)); // R1

endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chg_en,
  input  logic       src_ok,
  input  logic       f_low,
  input  logic       f_rch,
  input  logic       f_taper,
  input  logic       f_temp,
  input  logic       therm_reg,
  input  logic       pre_tmo,
  input  logic       fast_tmo,
  output chg_state_e st_nxt,
  output logic       pre_en,
  output logic       fast_en,
  output logic       flt_cur_en,
  output logic       tmr_rst,
  output logic       tmr_pre_run,
  output logic       tmr_fast_run,
  output logic       tmr_hold
);
  chg_state_e st_q, st_d, start_tgt, flt_tgt;
  logic       run_ok, enter_pre, enter_fast;

  assign run_ok    = chg_en && src_ok;
  assign start_tgt = f_low ? ST_PRE : ST_FAST;
  assign flt_tgt   = f_rch ? ST_FLT_PROBE : ST_FLT_WAIT;

  always_comb begin
    st_d = st_q;
    if (!run_ok) begin
      st_d = ST_SLEEP;
    end else begin
      case (st_q)
        ST_SLEEP:     st_d = start_tgt;
        ST_PRE: begin
          if (f_temp)       st_d = ST_SUSP_PRE;
          else if (!f_low)  st_d = ST_FAST;
          else if (pre_tmo) st_d = flt_tgt;
        end
        ST_FAST: begin
          if (f_temp)                      st_d = ST_SUSP_FAST;
          else if (fast_tmo)               st_d = flt_tgt;
          else if (f_taper && !therm_reg)  st_d = ST_DONE;
        end
        ST_DONE:      if (f_rch) st_d = start_tgt;
        ST_SUSP_PRE:  if (!f_temp) st_d = ST_PRE;
        ST_SUSP_FAST: if (!f_temp) st_d = ST_FAST;
        ST_FLT_PROBE: if (!f_rch) st_d = ST_FLT_WAIT;
        ST_FLT_WAIT:  if (f_rch) st_d = start_tgt;
        default:      st_d = ST_SLEEP;
      endcase
    end
  end

  assign st_nxt     = st_d;
  assign enter_pre  = (st_d == ST_PRE)  && (st_q != ST_PRE)  && (st_q != ST_SUSP_PRE);
  assign enter_fast = (st_d == ST_FAST) && (st_q != ST_FAST) && (st_q != ST_SUSP_FAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_SLEEP;
      pre_en       <= 1'b0;
      fast_en      <= 1'b0;
      flt_cur_en   <= 1'b0;
      tmr_rst      <= 1'b0;
      tmr_pre_run  <= 1'b0;
      tmr_fast_run <= 1'b0;
      tmr_hold     <= 1'b0;
    end else begin
      st_q         <= st_d;
      pre_en       <= (st_d == ST_PRE);
      fast_en      <= (st_d == ST_FAST);
      flt_cur_en   <= (st_d == ST_FLT_PROBE);
      tmr_rst      <= enter_pre || enter_fast;
      tmr_pre_run  <= (st_d == ST_PRE)  || (st_d == ST_SUSP_PRE);
      tmr_fast_run <= (st_d == ST_FAST) || (st_d == ST_SUSP_FAST);
      tmr_hold     <= (st_d == ST_SUSP_PRE) || (st_d == ST_SUSP_FAST);
    end
  end

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> (!pre_en && !fast_en && !flt_cur_en && !tmr_hold)); // R11
  AST_HOLD_FROM_CHG: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_hold) |-> $past(pre_en || fast_en)); // R7
  AST_RESUME_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    ($fell(tmr_hold) && (pre_en || fast_en)) |-> !tmr_rst); // R7
  AST_DONE_NEEDS_TAPER: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && $past(st_q) == ST_FAST) |-> $past(f_taper && !therm_reg)); // R5
  AST_FAST_FLT_TMO: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_FLT_PROBE || st_q == ST_FLT_WAIT) && $past(st_q) == ST_FAST)
      |-> $past(fast_tmo)); // R4

endmodule

// File: rtl/chg_stat_enc.sv
module chg_stat_enc
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  chg_state_e st_nxt,
  output logic       stat1_on,
  output logic       stat2_on
);
  logic s1_d, s2_d;

  always_comb begin
    case (st_nxt)
      ST_PRE:  begin s1_d = 1'b1; s2_d = 1'b1; end
      ST_FAST: begin s1_d = 1'b1; s2_d = 1'b0; end
      ST_DONE: begin s1_d = 1'b0; s2_d = 1'b1; end
      default: begin s1_d = 1'b0; s2_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat1_on <= 1'b0;
      stat2_on <= 1'b0;
    end else begin
      stat1_on <= s1_d;
      stat2_on <= s2_d;
    end
  end

endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
  import chg_pkg::*;
#(
  parameter int unsigned DG_TICKS = 22500
) (
  input  logic clk,
  input  logic rst,
  input  logic chg_en,
  input  logic src_ok,
  input  logic bat_low_raw,
  input  logic bat_rch_raw,
  input  logic taper_raw,
  input  logic temp_bad_raw,
  input  logic therm_reg,
  input  logic pre_tmo,
  input  logic fast_tmo,
  output logic pre_en,
  output logic fast_en,
  output logic flt_cur_en,
  output logic tmr_rst,
  output logic tmr_pre_run,
  output logic tmr_fast_run,
  output logic tmr_hold,
  output logic stat1_on,
  output logic stat2_on
);
  logic [NUM_FLAGS-1:0] flag_raw, flag_f;
  chg_state_e           st_nxt;

  assign flag_raw[FL_LOW]   = bat_low_raw;
  assign flag_raw[FL_RCH]   = bat_rch_raw;
  assign flag_raw[FL_TAPER] = taper_raw;
  assign flag_raw[FL_TEMP]  = temp_bad_raw;

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_dg
    chg_deglitch #(.TICKS(DG_TICKS)) dg_i (
      .clk (clk),
      .rst (rst),
      .raw (flag_raw[gi]),
      .flt (flag_f[gi])
    );
  end

  chg_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .chg_en       (chg_en),
    .src_ok       (src_ok),
    .f_low        (flag_f[FL_LOW]),
    .f_rch        (flag_f[FL_RCH]),
    .f_taper      (flag_f[FL_TAPER]),
    .f_temp       (flag_f[FL_TEMP]),
    .therm_reg    (therm_reg),
    .pre_tmo      (pre_tmo),
    .fast_tmo     (fast_tmo),
    .st_nxt       (st_nxt),
    .pre_en       (pre_en),
    .fast_en      (fast_en),
    .flt_cur_en   (flt_cur_en),
    .tmr_rst      (tmr_rst),
    .tmr_pre_run  (tmr_pre_run),
    .tmr_fast_run (tmr_fast_run),
    .tmr_hold     (tmr_hold)
  );

  chg_stat_enc enc_i (
    .clk      (clk),
    .rst      (rst),
    .st_nxt   (st_nxt),
    .stat1_on (stat1_on),
    .stat2_on (stat2_on)
  );

  AST_STAT_PRE: assert property (@(posedge clk) disable iff (rst)
    pre_en |-> (stat1_on && stat2_on)); // R8
  AST_STAT_FAST: assert property (@(posedge clk) disable iff (rst)
    fast_en |-> (stat1_on && !stat2_on)); // R8
  AST_STAT_PROBE: assert property (@(posedge clk) disable iff (rst)
    flt_cur_en |-> (!stat1_on && !stat2_on)); // R10

endmodule

// File: tb/chg_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module chg_cycle_ctrl_tb_top;
  localparam int DG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chg_en = 1'b0, src_ok = 1'b0;
  logic bat_low_raw = 1'b0, bat_rch_raw = 1'b0, taper_raw = 1'b0, temp_bad_raw = 1'b0;
  logic therm_reg = 1'b0, pre_tmo = 1'b0, fast_tmo = 1'b0;
  logic pre_en, fast_en, flt_cur_en, tmr_rst, tmr_pre_run, tmr_fast_run, tmr_hold;
  logic stat1_on, stat2_on;

  int checks = 0;
  int fails  = 0;
  int rst_cnt = 0;
  int hold_cnt = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  chg_cycle_ctrl #(.DG_TICKS(DG)) dut_i (
    .clk(clk), .rst(rst), .chg_en(chg_en), .src_ok(src_ok),
    .bat_low_raw(bat_low_raw), .bat_rch_raw(bat_rch_raw), .taper_raw(taper_raw),
    .temp_bad_raw(temp_bad_raw), .therm_reg(therm_reg), .pre_tmo(pre_tmo),
    .fast_tmo(fast_tmo), .pre_en(pre_en), .fast_en(fast_en), .flt_cur_en(flt_cur_en),
    .tmr_rst(tmr_rst), .tmr_pre_run(tmr_pre_run), .tmr_fast_run(tmr_fast_run),
    .tmr_hold(tmr_hold), .stat1_on(stat1_on), .stat2_on(stat2_on)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference states: 0 sleep,1 pre,2 fast,3 done,4 susp-pre,5 susp-fast,6 probe,7 wait
  function automatic int ref_next(int c, bit ok, bit lo, bit rc, bit tp, bit tm,
                                  bit th, bit pt, bit ft);
    int st;
    int fl;
    st = lo ? 1 : 2;
    fl = rc ? 6 : 7;
    if (!ok) return 0;
    case (c)
      0: return st;
      1: if (tm) return 4; else if (!lo) return 2; else if (pt) return fl; else return 1;
      2: if (tm) return 5; else if (ft) return fl; else if (tp && !th) return 3; else return 2;
      3: return rc ? st : 3;
      4: return tm ? 4 : 1;
      5: return tm ? 5 : 2;
      6: return rc ? 6 : 7;
      7: return rc ? st : 7;
      default: return 0;
    endcase
  endfunction

  int m_st = 0;
  bit m_flt [4];
  int m_cnt [4];
  bit m_pre, m_fast, m_fc, m_rst, m_prun, m_frun, m_hold, m_s1, m_s2;

  always @(posedge clk) begin
    bit raw [4];
    int ns;
    if (tmr_rst) rst_cnt++;
    if (tmr_hold) hold_cnt++;
    raw[0] = bat_low_raw; raw[1] = bat_rch_raw; raw[2] = taper_raw; raw[3] = temp_bad_raw;
    if (rst) begin
      m_st = 0;
      for (int i = 0; i < 4; i++) begin m_flt[i] = 1'b0; m_cnt[i] = 0; end
      {m_pre, m_fast, m_fc, m_rst, m_prun, m_frun, m_hold, m_s1, m_s2} = '0;
    end else begin
      ns = ref_next(m_st, chg_en && src_ok, m_flt[0], m_flt[1], m_flt[2], m_flt[3],
                    therm_reg, pre_tmo, fast_tmo);
      m_pre  = (ns == 1);
      m_fast = (ns == 2);
      m_fc   = (ns == 6);
      m_hold = (ns == 4) || (ns == 5);
      m_prun = (ns == 1) || (ns == 4);
      m_frun = (ns == 2) || (ns == 5);
      m_rst  = ((ns == 1) && m_st != 1 && m_st != 4) || ((ns == 2) && m_st != 2 && m_st != 5);
      m_s1   = (ns == 1) || (ns == 2);
      m_s2   = (ns == 1) || (ns == 3);
      m_st   = ns;
      for (int i = 0; i < 4; i++) begin
        if (raw[i] == m_flt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == DG - 1) begin m_flt[i] = raw[i]; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 pre_en vs reference", pre_en, m_pre);
      chk("R2 fast_en vs reference", fast_en, m_fast);
      chk("R10 flt_cur_en vs reference", flt_cur_en, m_fc);
      chk("R3 tmr_rst vs reference", tmr_rst, m_rst);
      chk("R7 tmr_pre_run vs reference", tmr_pre_run, m_prun);
      chk("R7 tmr_fast_run vs reference", tmr_fast_run, m_frun);
      chk("R7 tmr_hold vs reference", tmr_hold, m_hold);
      chk("R8 stat1_on vs reference", stat1_on, m_s1);
      chk("R8 stat2_on vs reference", stat2_on, m_s2);
    end
  end

  task automatic settle();
    repeat (DG + 4) @(negedge clk);
  endtask

  task automatic pulse_pre();
    pre_tmo = 1'b1; @(negedge clk); pre_tmo = 1'b0;
  endtask

  task automatic pulse_fast();
    fast_tmo = 1'b1; @(negedge clk); fast_tmo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rc;
    int hc;
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12 pre_en in reset", pre_en, 1'b0);
    chk("R12 fast_en in reset", fast_en, 1'b0);
    chk("R12 stat1_on in reset", stat1_on, 1'b0);
    chk("R12 tmr_hold in reset", tmr_hold, 1'b0);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R12 flt_cur_en after reset", flt_cur_en, 1'b0);

    // prime filters while disabled
    src_ok = 1'b1; bat_low_raw = 1'b1; bat_rch_raw = 1'b1;
    settle();
    chk("R11 idle while chg_en low", pre_en, 1'b0);
    chg_en = 1'b1;
    @(negedge clk);
    chk("R2 precharge on start", pre_en, 1'b1);
    chk("R2 timer clear on start", tmr_rst, 1'b1);
    chk("R2 precharge timer runs", tmr_pre_run, 1'b1);
    chk("R8 precharge stat1", stat1_on, 1'b1);
    chk("R8 precharge stat2", stat2_on, 1'b1);

    // R7: suspend in precharge
    temp_bad_raw = 1'b1;
    settle();
    chk("R7 suspend drops precharge", pre_en, 1'b0);
    chk("R7 suspend holds timers", tmr_hold, 1'b1);
    chk("R7 suspend keeps run bit", tmr_pre_run, 1'b1);
    chk("R8 suspend stat1", stat1_on, 1'b0);
    pulse_pre();
    settle();
    chk("R7 timeout ignored while suspended", tmr_hold, 1'b1);
    chk("R7 no fault current while suspended", flt_cur_en, 1'b0);
    rc = rst_cnt;
    temp_bad_raw = 1'b0;
    settle();
    chk("R7 resume precharge", pre_en, 1'b1);
    chk("R7 resume without timer clear", rst_cnt == rc, 1'b1);

    // R4/R10: precharge timeout below recharge threshold
    pulse_pre();
    @(negedge clk);
    chk("R4 fault drops precharge", pre_en, 1'b0);
    chk("R10 fault probe current on", flt_cur_en, 1'b1);
    chk("R8 fault stat2", stat2_on, 1'b0);
    bat_rch_raw = 1'b0;
    settle();
    chk("R10 probe current off above threshold", flt_cur_en, 1'b0);
    chk("R9 waiting, no charge", pre_en | fast_en, 1'b0);
    bat_rch_raw = 1'b1;
    settle();
    chk("R9 new cycle after drop", pre_en, 1'b1);

    // R3: precharge to fast charge
    rc = rst_cnt;
    bat_low_raw = 1'b0; bat_rch_raw = 1'b0;
    settle();
    chk("R3 fast charge entered", fast_en, 1'b1);
    chk("R3 timer cleared on phase change", rst_cnt == rc + 1, 1'b1);
    chk("R3 fast timer runs", tmr_fast_run, 1'b1);
    chk("R8 fast stat2", stat2_on, 1'b0);

    // R5: taper masked by thermal regulation
    therm_reg = 1'b1; taper_raw = 1'b1;
    settle();
    chk("R5 taper ignored under thermal regulation", fast_en, 1'b1);
    therm_reg = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 done entered", fast_en, 1'b0);
    chk("R8 done stat1", stat1_on, 1'b0);
    chk("R8 done stat2", stat2_on, 1'b1);
    taper_raw = 1'b0;
    settle();
    chk("R6 done holds above threshold", stat2_on, 1'b1);
    bat_rch_raw = 1'b1;
    settle();
    chk("R6 recharge restarts cycle", fast_en, 1'b1);

    // R9: fast timeout above recharge threshold
    bat_rch_raw = 1'b0;
    settle();
    pulse_fast();
    settle();
    chk("R4 fault drops fast charge", fast_en, 1'b0);
    chk("R9 no probe current above threshold", flt_cur_en, 1'b0);
    bat_rch_raw = 1'b1;
    settle();
    chk("R9 recovery to fast charge", fast_en, 1'b1);

    // R1: short temperature excursion swallowed
    hc = hold_cnt;
    temp_bad_raw = 1'b1;
    repeat (DG - 1) @(negedge clk);
    temp_bad_raw = 1'b0;
    settle();
    chk("R1 short glitch keeps fast charge", fast_en, 1'b1);
    chk("R1 short glitch never holds", hold_cnt == hc, 1'b1);

    // R11: enable toggle clears fault
    pulse_fast();
    @(negedge clk);
    chk("R10 probe current after fast fault", flt_cur_en, 1'b1);
    chg_en = 1'b0;
    @(negedge clk);
    chk("R11 disable clears probe", flt_cur_en, 1'b0);
    chk("R11 disable stat", stat1_on | stat2_on, 1'b0);
    chg_en = 1'b1;
    @(negedge clk);
    chk("R11 fault cleared by toggle", fast_en, 1'b1);
    src_ok = 1'b0;
    @(negedge clk);
    chk("R11 source loss stops charge", fast_en, 1'b0);
    src_ok = 1'b1;

    // random phase, compared every cycle against the reference
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if ($urandom_range(199) == 0) bat_low_raw  = ~bat_low_raw;
      if ($urandom_range(149) == 0) bat_rch_raw  = ~bat_rch_raw;
      if ($urandom_range(99)  == 0) taper_raw    = ~taper_raw;
      if ($urandom_range(299) == 0) temp_bad_raw = ~temp_bad_raw;
      if ($urandom_range(49)  == 0) therm_reg    = ~therm_reg;
      if ($urandom_range(799) == 0) chg_en       = ~chg_en;
      if ($urandom_range(899) == 0) src_ok       = ~src_ok;
      pre_tmo  = ($urandom_range(119) == 0);
      fast_tmo = ($urandom_range(399) == 0);
    end
    @(negedge clk);
    cmp_on = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule